// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block decodes a small I/O window that holds one 8-byte register set for each IDE channel. The first four bytes of a set are byte-wide control and status registers. The last four bytes hold a 32-bit pointer to that channel's descriptor table. The control registers are:

- a command byte, which is handed to the DMA transfer engine;
- a per-channel view of a mode register that the channels share and the interrupt block owns;
- a status register whose bits behave in different ways;
- a per-channel UDMA timing byte.

The transfer engine is outside this block. It receives the latched command byte and a one-cycle write pulse. It drives the status active bit, and it raises the status error and interrupt bits through set inputs. Writes to the mode register are not stored here. The merged new value is sent to the interrupt block.

All accesses come through a single-cycle request port. Every request is accepted in the cycle `acc_valid` is high. Read data returns one cycle later with `rd_valid`. Write side effects on the outputs also appear one cycle after the request.

Top module: `busmaster_regwin`

## Requirements
- R1: Address bit 3 selects the channel (0 or 1). Address bit 2 selects the part: 0 is the control part, 1 is the descriptor pointer. Address bits [1:0] give the byte offset. An access to one channel never changes the other channel's registers.
- R2: The control part accepts only byte accesses (`acc_size` = 0). A wider read returns all ones across the access width: 0x0000FFFF for size 1, and 0xFFFFFFFF for sizes 2 and 3. A wider write has no effect. Every read returns its data on `rd_data` with `rd_valid` high in the cycle after the request.
- R3: A byte write at offset 0 latches the command byte for the channel. In the next cycle `cmd_byte` shows the new value and that channel's bit of `cmd_wr` pulses high for one cycle. A read at offset 0 returns the latched byte.
- R4: A read at offset 1 returns `mode_in`. A byte write of value v at offset 1 pulses `mode_wr` in the next cycle with `mode_wdata` = (`mode_in` & ~0x30) | (v & 0x30).
- R5: A byte write of v at offset 2 sets status bits 6:5 to v[6:5]. It clears each of status bits 2:1 where v has a one and keeps the others. Status bits 7, 4 and 3 always read 0.
- R6: Status bit 0 reads the channel's `eng_active` input as sampled at the previous clock edge. Writes never change it.
- R7: A high `eng_err_set` sets status bit 1 and a high `eng_irq_set` sets status bit 2, both at the next edge. A set wins over a write-one-to-clear in the same cycle.
- R8: Offset 3 reads and writes the channel's UDMA timing byte, which is driven on `udma_timing` (channel c at bits [8c+7:8c]).
- R9: The descriptor pointer accepts byte, 16-bit and 32-bit accesses. Byte k of an access maps to pointer byte (offset + k), and bytes beyond the pointer end are ignored on writes and read as 0xFF. Pointer bits [1:0] always read 0. The pointer is driven on `desc_ptr`.
- R10: Reset clears the command, status, timing and pointer registers, and the outputs `cmd_wr`, `mode_wr` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte address in the window |
| acc_size | input | 2 | 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit |
| acc_wdata | input | 32 | Write data, lowest byte at the addressed byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| mode_in | input | 8 | Current shared mode register value |
| mode_wr | output | 1 | Mode register update pulse |
| mode_wdata | output | 8 | Merged new mode register value |
| cmd_wr | output | 2 | Per-channel command write pulse |
| cmd_byte | output | 16 | Latched command bytes |
| eng_active | input | 2 | Engine active flag per channel |
| eng_err_set | input | 2 | Engine error event per channel |
| eng_irq_set | input | 2 | Engine interrupt event per channel |
| udma_timing | output | 16 | UDMA timing bytes |
| desc_ptr | output | 64 | Descriptor table pointers |

## Verification
The hardest case to reach from the ports is an engine event that sets a status bit in the same cycle that software writes a one to clear that bit. The bench lines up the `eng_err_set` pulse and the status write on the same edge. It first drives both event inputs so that both bits start set. It then checks that the bit with the coinciding event stays set while the other bit clears. The sweep also raises both event bits before every write, so every status write pattern meets live write-one-to-clear bits. It then reads back every offset at every size on both channels, which checks that the channels stay isolated.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int BYTE_W     = 8;
  localparam int PTR_W      = 32;
  localparam int BUS_W      = 32;
  localparam int PART_BYTES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_TIM  = 2'd3
  } ctrl_reg_e;

  localparam logic [7:0] STAT_THRU  = 8'h60;
  localparam logic [7:0] STAT_W1C   = 8'h06;
  localparam logic [7:0] STAT_ZERO  = 8'h98;
  localparam logic [7:0] MODE_WMASK = 8'h30;

  function automatic logic [3:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001;
      SZ_HALF: lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 4
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [BUS_W-1:0]  acc_wdata,
  output logic [CH_W-1:0]   ch_idx,
  output logic [NUM_CH-1:0] ch_hit,
  output logic              is_ptr,
  output logic [1:0]        lane_off,
  output logic [3:0]        ctrl_we,
  output logic [3:0]        ptr_be,
  output logic [PTR_W-1:0]  ptr_wd,
  output logic [7:0]        wbyte
);
  logic       wr_any;
  logic [7:0] be_wide;

  assign wr_any   = acc_valid && acc_write;
  assign is_ptr   = acc_addr[2];
  assign lane_off = acc_addr[1:0];
  assign wbyte    = acc_wdata[7:0];

  generate
    if (NUM_CH > 1) begin : g_multi
      assign ch_idx = acc_addr[ADDR_W-1:3];
    end else begin : g_single
      logic unused_hi;
      assign unused_hi = acc_addr[ADDR_W-1];
      assign ch_idx    = '0;
    end
  endgenerate

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit[c] = (ch_idx == CH_W'(c));
  end

  // control part: byte writes only
  always_comb begin
    ctrl_we = 4'b0000;
    if (wr_any && !is_ptr && acc_size == SZ_BYTE)
      ctrl_we = 4'b0001 << lane_off;
  end

  // pointer part: lanes shifted to the addressed byte, overflow dropped
  assign be_wide = {4'b0000, lane_mask(acc_size)} << lane_off;
  assign ptr_be  = (wr_any && is_ptr) ? be_wide[3:0] : 4'b0000;
  assign ptr_wd  = acc_wdata << {lane_off, 3'b000};
endmodule

// File: rtl/bmw_chan_regs.sv
module bmw_chan_regs
  import bmw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [3:0]       ctrl_we,
  input  logic [7:0]       wbyte,
  input  logic [3:0]       ptr_be,
  input  logic [PTR_W-1:0] ptr_wd,
  input  logic             active_in,
  input  logic             err_set,
  input  logic             irq_set,
  output logic [7:0]       cmd_q,
  output logic             cmd_pulse,
  output logic [7:0]       stat_q,
  output logic [7:0]       tim_q,
  output logic [PTR_W-1:0] ptr_q
);
  logic [3:0]       we;
  logic [3:0]       be;
  logic [7:0]       stat_nx;
  logic [PTR_W-1:2] ptr_hi;

  assign we = ctrl_we & {4{hit}};
  assign be = ptr_be & {4{hit}};

  always_comb begin
    stat_nx = stat_q;
    if (we[REG_STAT])
      stat_nx = (wbyte & STAT_THRU) | (stat_q & ~wbyte & STAT_W1C);
    stat_nx[0] = active_in;
    if (err_set) stat_nx[1] = 1'b1;
    if (irq_set) stat_nx[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      cmd_pulse <= 1'b0;
      stat_q    <= '0;
      tim_q     <= '0;
    end else begin
      cmd_pulse <= we[REG_CMD];
      if (we[REG_CMD]) cmd_q <= wbyte;
      if (we[REG_TIM]) tim_q <= wbyte;
      stat_q <= stat_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi <= '0;
    end else begin
      for (int j = 0; j < PART_BYTES; j++) begin
        if (be[j]) begin
          if (j == 0) ptr_hi[7:2] <= ptr_wd[7:2];
          else        ptr_hi[j*8 +: 8] <= ptr_wd[j*8 +: 8];
        end
      end
    end
  end

  assign ptr_q = {ptr_hi, 2'b00};

  a_r6_active_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_q[0] == $past(active_in));
  a_r7_err_sets: assert property (@(posedge clk) disable iff (rst)
    err_set |=> stat_q[1]);
  a_r7_irq_sets: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> stat_q[2]);
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (we[REG_STAT] && wbyte[1] && !err_set) |=> !stat_q[1]);
  a_r5_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (stat_q & STAT_ZERO) == 8'h00);
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (be == 4'b0000) |=> $stable(ptr_q));
endmodule

// File: rtl/bmw_rdmux.sv
module bmw_rdmux
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic [CH_W-1:0]               ch_idx,
  input  logic                          is_ptr,
  input  logic [1:0]                    lane_off,
  input  logic [1:0]                    acc_size,
  input  logic [7:0]                    mode_in,
  input  logic [NUM_CH-1:0][7:0]        cmd_arr,
  input  logic [NUM_CH-1:0][7:0]        stat_arr,
  input  logic [NUM_CH-1:0][7:0]        tim_arr,
  input  logic [NUM_CH-1:0][PTR_W-1:0]  ptr_arr,
  output logic [BUS_W-1:0]              rdata
);
  logic [63:0] ptr_ext;
  logic [63:0] ptr_sh;
  logic [7:0]  ctrl_byte;

  assign ptr_ext = {32'hFFFF_FFFF, ptr_arr[ch_idx]};
  assign ptr_sh  = ptr_ext >> {lane_off, 3'b000};

  always_comb begin
    case (ctrl_reg_e'(lane_off))
      REG_CMD:  ctrl_byte = cmd_arr[ch_idx];
      REG_MODE: ctrl_byte = mode_in;
      REG_STAT: ctrl_byte = stat_arr[ch_idx];
      default:  ctrl_byte = tim_arr[ch_idx];
    endcase
  end

  always_comb begin
    if (is_ptr)
      rdata = ptr_sh[31:0] & width_mask(acc_size);
    else if (acc_size != SZ_BYTE)
      rdata = width_mask(acc_size);
    else
      rdata = {24'h0, ctrl_byte};
  end
endmodule

// File: rtl/busmaster_regwin.sv
module busmaster_regwin
  import bmw_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [1:0]             acc_size,
  input  logic [31:0]            acc_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data,
  input  logic [7:0]             mode_in,
  output logic                   mode_wr,
  output logic [7:0]             mode_wdata,
  output logic [NUM_CH-1:0]      cmd_wr,
  output logic [NUM_CH*8-1:0]    cmd_byte,
  input  logic [NUM_CH-1:0]      eng_active,
  input  logic [NUM_CH-1:0]      eng_err_set,
  input  logic [NUM_CH-1:0]      eng_irq_set,
  output logic [NUM_CH*8-1:0]    udma_timing,
  output logic [NUM_CH*32-1:0]   desc_ptr
);
  logic [CH_W-1:0]              ch_idx;
  logic [NUM_CH-1:0]            ch_hit;
  logic                         is_ptr;
  logic [1:0]                   lane_off;
  logic [3:0]                   ctrl_we;
  logic [3:0]                   ptr_be;
  logic [PTR_W-1:0]             ptr_wd;
  logic [7:0]                   wbyte;
  logic [NUM_CH-1:0][7:0]       cmd_arr;
  logic [NUM_CH-1:0][7:0]       stat_arr;
  logic [NUM_CH-1:0][7:0]       tim_arr;
  logic [NUM_CH-1:0][PTR_W-1:0] ptr_arr;
  logic [BUS_W-1:0]             rdata_c;

  bmw_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .ch_idx    (ch_idx),
    .ch_hit    (ch_hit),
    .is_ptr    (is_ptr),
    .lane_off  (lane_off),
    .ctrl_we   (ctrl_we),
    .ptr_be    (ptr_be),
    .ptr_wd    (ptr_wd),
    .wbyte     (wbyte)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmw_chan_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .hit       (ch_hit[c]),
      .ctrl_we   (ctrl_we),
      .wbyte     (wbyte),
      .ptr_be    (ptr_be),
      .ptr_wd    (ptr_wd),
      .active_in (eng_active[c]),
      .err_set   (eng_err_set[c]),
      .irq_set   (eng_irq_set[c]),
      .cmd_q     (cmd_arr[c]),
      .cmd_pulse (cmd_wr[c]),
      .stat_q    (stat_arr[c]),
      .tim_q     (tim_arr[c]),
      .ptr_q     (ptr_arr[c])
    );
    assign cmd_byte[c*8 +: 8]     = cmd_arr[c];
    assign udma_timing[c*8 +: 8]  = tim_arr[c];
    assign desc_ptr[c*32 +: 32]   = ptr_arr[c];
  end

  bmw_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .ch_idx   (ch_idx),
    .is_ptr   (is_ptr),
    .lane_off (lane_off),
    .acc_size (acc_size),
    .mode_in  (mode_in),
    .cmd_arr  (cmd_arr),
    .stat_arr (stat_arr),
    .tim_arr  (tim_arr),
    .ptr_arr  (ptr_arr),
    .rdata    (rdata_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      mode_wr    <= 1'b0;
      mode_wdata <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= rdata_c;
      mode_wr <= ctrl_we[REG_MODE];
      if (ctrl_we[REG_MODE])
        mode_wdata <= (mode_in & ~MODE_WMASK) | (wbyte & MODE_WMASK);
    end
  end

  a_r2_rd_latency: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);
  a_r2_wide_ctrl_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && !acc_addr[2] && acc_size != 2'd0)
      |=> (cmd_wr == '0 && !mode_wr));
  a_r3_cmd_pulse_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_wr));
  a_r4_mode_keeps_unmasked: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && !acc_addr[2] && acc_addr[1:0] == 2'd1 &&
     acc_size == 2'd0) |=> (mode_wr && (mode_wdata & 8'hCF) == ($past(mode_in) & 8'hCF)));
endmodule

// File: tb/busmaster_regwin_tb_top.sv
module busmaster_regwin_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [3:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  mode_in;
  logic        mode_wr;
  logic [7:0]  mode_wdata;
  logic [1:0]  cmd_wr;
  logic [15:0] cmd_byte;
  logic [1:0]  eng_active, eng_err_set, eng_irq_set;
  logic [15:0] udma_timing;
  logic [63:0] desc_ptr;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_stat[2];
  logic [7:0]  m_tim [2];
  logic [31:0] m_ptr [2];

  always #10 clk = ~clk;

  busmaster_regwin dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mode_in(mode_in),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .cmd_wr(cmd_wr),
    .cmd_byte(cmd_byte), .eng_active(eng_active), .eng_err_set(eng_err_set),
    .eng_irq_set(eng_irq_set), .udma_timing(udma_timing), .desc_ptr(desc_ptr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_rd(input int ch, input int off, input int sz);
    logic [63:0] ext;
    if (off < 4) begin
      if (sz != 0) return wmask(sz);
      case (off)
        0: return {24'h0, m_cmd[ch]};
        1: return {24'h0, mode_in};
        2: return {24'h0, m_stat[ch] | {7'h0, eng_active[ch]}};
        default: return {24'h0, m_tim[ch]};
      endcase
    end
    ext = {32'hFFFF_FFFF, m_ptr[ch]} >> ((off - 4) * 8);
    return ext[31:0] & wmask(sz);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_stat[c] = 0; m_tim[c] = 0; m_ptr[c] = 0;
    end
  endtask

  // one access; outputs sampled at the negedge after the capturing posedge
  task automatic access(input bit wr, input int ch, input int off, input int sz,
                        input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_addr = 4'((ch << 3) | off);
    acc_size = 2'(sz); acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd_chk(input string req, input int ch, input int off, input int sz);
    logic [31:0] e;
    e = exp_rd(ch, off, sz);
    access(0, ch, off, sz, 32'h0);
    chk({req, " rd_valid"}, {63'h0, rd_valid}, 64'h1);
    chk(req, {32'h0, rd_data}, {32'h0, e});
  endtask

  task automatic model_write(input int ch, input int off, input int sz, input logic [31:0] v);
    int nb;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (off < 4) begin
      if (sz == 0) begin
        case (off)
          0: m_cmd[ch] = v[7:0];
          2: m_stat[ch] = (v[7:0] & 8'h60) | (m_stat[ch] & ~v[7:0] & 8'h06);
          3: m_tim[ch] = v[7:0];
          default: ;
        endcase
      end
    end else begin
      for (int k = 0; k < 4; k++)
        if (k < nb && (off - 4 + k) < 4)
          m_ptr[ch][(off - 4 + k) * 8 +: 8] = v[k*8 +: 8];
      m_ptr[ch][1:0] = 2'b00;
    end
  endtask

  task automatic check_outs(input string req);
    chk({req, " cmd_byte"}, {48'h0, cmd_byte}, {48'h0, m_cmd[1], m_cmd[0]});
    chk({req, " udma_timing"}, {48'h0, udma_timing}, {48'h0, m_tim[1], m_tim[0]});
    chk({req, " desc_ptr"}, desc_ptr, {m_ptr[1], m_ptr[0]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h5A3C_E1F7; pats[1] = 32'hA5C3_1E09; pats[2] = 32'h0000_0000;
    rst = 1; acc_valid = 0; acc_write = 0; acc_addr = 0; acc_size = 0; acc_wdata = 0;
    mode_in = 8'hC9; eng_active = 0; eng_err_set = 0; eng_irq_set = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state at the ports and in every register
    chk("R10 rd_valid", {63'h0, rd_valid}, 64'h0);
    chk("R10 cmd_wr", {62'h0, cmd_wr}, 64'h0);
    chk("R10 mode_wr", {63'h0, mode_wr}, 64'h0);
    check_outs("R10");
    rst = 0;
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++) rd_chk("R10 reset readback", c, o, 0);

    // R1 R2 R3 R4 R5 R8 R9: sweep every channel, offset, size and pattern
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            eng_err_set[c] = 1; eng_irq_set[c] = 1;
            @(negedge clk);
            eng_err_set = 0; eng_irq_set = 0;
            m_stat[c] = m_stat[c] | 8'h06;
            access(1, c, o, s, pats[p] ^ {24'h0, 8'(o * 16 + s)});
            chk("R3 cmd_wr pulse", {62'h0, cmd_wr},
                (o == 0 && s == 0) ? (64'h1 << c) : 64'h0);
            chk("R4 mode_wr pulse", {63'h0, mode_wr}, (o == 1 && s == 0) ? 64'h1 : 64'h0);
            if (o == 1 && s == 0)
              chk("R4 mode_wdata", {56'h0, mode_wdata},
                  {56'h0, (mode_in & 8'hCF) | (pats[p][7:0] ^ 8'(o * 16 + s)) & 8'h30});
            model_write(c, o, s, pats[p] ^ {24'h0, 8'(o * 16 + s)});
            check_outs("R9 R8 R3 R1 outputs");
            for (int rc = 0; rc < 2; rc++)
              for (int ro = 0; ro < 8; ro++)
                for (int rs = 0; rs < 3; rs++)
                  rd_chk("R1 R2 R5 R9 readback", rc, ro, rs);
          end

    // R6: active bit follows the engine and ignores writes
    @(negedge clk); eng_active = 2'b10;
    @(negedge clk);
    rd_chk("R6 active set", 1, 2, 0);
    access(1, 1, 2, 0, 32'h0000_00FF);
    model_write(1, 2, 0, 32'hFF);
    rd_chk("R6 active after write", 1, 2, 0);
    rd_chk("R6 other channel idle", 0, 2, 0);
    @(negedge clk); eng_active = 2'b00;
    @(negedge clk);
    rd_chk("R6 active clear", 1, 2, 0);

    // R7: event set wins over a same-cycle write-one-to-clear
    @(negedge clk); eng_err_set = 2'b01; eng_irq_set = 2'b01;
    @(negedge clk); eng_err_set = 0; eng_irq_set = 0;
    m_stat[0] = m_stat[0] | 8'h06;
    rd_chk("R7 both set", 0, 2, 0);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = 4'h2; acc_size = 0; acc_wdata = 32'h06;
    eng_err_set = 2'b01;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; eng_err_set = 0;
    m_stat[0] = (m_stat[0] & 8'h60) | 8'h02;
    m_stat[0][6:5] = 2'b00;
    rd_chk("R7 set beats clear", 0, 2, 0);

    // R10: reset mid-run clears everything written so far
    access(1, 0, 0, 0, 32'h77); model_write(0, 0, 0, 32'h77);
    access(1, 1, 4, 2, 32'hDEAD_BEEF); model_write(1, 4, 2, 32'hDEAD_BEEF);
    do_reset();
    check_outs("R10 after reset");
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++) rd_chk("R10 readback after reset", c, o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule